// File: doc/BRIEF.md
# Seven-Register Bus Datapath

This block is the execution core of a small register-transfer engine. Seven general registers, named R1 to R7, feed two source selectors. One selector drives operand bus A and the other drives operand bus B, and both buses feed an arithmetic/logic unit. Each clock cycle the block takes one 14-bit control word and one external data word. The control word chooses both sources, the destination and the operation. The ALU result appears combinationally on an output port. On the next rising clock edge the result is written into the chosen destination register, unless the destination code discards it.

The block does not fetch or decode instructions and has no memory of its own. Whatever sits upstream builds the control words. The external data word is how values enter the register file, and the result port is how they leave it. The data width is a parameter that defaults to 8 bits.

Top module: `dp7_datapath`

## Requirements
- R1: While the active-low reset is asserted, all seven registers are cleared to zero. When reset is released, reading any register returns zero.
- R2: The control word is {src_a[13:11], src_b[10:8], dst[7:5], op[4:0]}. On either source field, code 1 to 7 places register R1 to R7 on that bus, and code 0 places `ext_in` on that bus.
- R3: `result_out` shows the ALU result for the current control word and `ext_in` in the same cycle, with no register in between.
- R4: A nonzero `dst` code n writes the result into Rn at the rising clock edge. No other register changes.
- R5: Code 0 on `dst` writes no register, so the result is only seen on `result_out`.
- R6: Arithmetic operations, all modulo 2^W: op 00000 gives A, 00001 gives A+1, 00010 gives A+B, 00101 gives A-B, and 00110 gives A-1.
- R7: Bitwise operations: op 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B, and 01110 gives NOT A.
- R8: Shift operations: op 10000 shifts A right by one with a zero entering the MSB, and op 11000 shifts A left by one with a zero entering the LSB.
- R9: Any op code not listed above passes A through unchanged.
- R10: A register may be both a source and the destination in one control word. The operation uses the value the register held before the edge, and the new value can be read from the following cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes occur on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset that clears all registers |
| ctrl_word | input | 14 | Packed source A, source B, destination and operation fields |
| ext_in | input | DATA_W | External data word, selected onto a bus by source code 0 |
| result_out | output | DATA_W | Combinational ALU result |

## Verification
Two functions can fall in the same cycle: the read of a register onto an operand bus and the write of that same register by the destination decoder. The bench provokes this with control words that name one register as source and destination, such as R6 = R6 + R6 and R3 = R3 - 1. It judges the outcome in two places. `result_out` must be computed from the old value during the cycle, and a later read-only control word must show exactly the updated value in that register while the other six are unchanged.

// File: rtl/dp7_pkg.sv
package dp7_pkg;
  localparam int SEL_W = 3;
  localparam int OP_W  = 5;
  localparam int CW_W  = 3 * SEL_W + OP_W;
  localparam int NREG  = (1 << SEL_W) - 1;

  typedef enum logic [OP_W-1:0] {
    OP_PASS = 5'b00000,
    OP_INC  = 5'b00001,
    OP_ADD  = 5'b00010,
    OP_SUB  = 5'b00101,
    OP_DEC  = 5'b00110,
    OP_AND  = 5'b01000,
    OP_OR   = 5'b01010,
    OP_XOR  = 5'b01100,
    OP_NOT  = 5'b01110,
    OP_SHR  = 5'b10000,
    OP_SHL  = 5'b11000
  } alu_op_e;

  typedef struct packed {
    logic [SEL_W-1:0] src_a;
    logic [SEL_W-1:0] src_b;
    logic [SEL_W-1:0] dst;
    logic [OP_W-1:0]  op;
  } ctrl_t;
endpackage

// File: rtl/dp7_regfile.sv
module dp7_regfile
  import dp7_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NREG-1:0][DATA_W-1:0]  rd_all
);
  logic [NREG-1:0] wr_en;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] d;

    assign wr_en[g] = (wr_sel == SEL_W'(g + 1));

    always_comb begin
      d = q;
      if (wr_en[g]) d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign rd_all[g] = q;
  end

  // A discarded result must leave every register untouched
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel == '0) |=> $stable(rd_all));
endmodule

// File: rtl/dp7_bus_mux.sv
module dp7_bus_mux
  import dp7_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [SEL_W-1:0]             sel,
  input  logic [DATA_W-1:0]            ext,
  input  logic [NREG-1:0][DATA_W-1:0]  regs,
  output logic [DATA_W-1:0]            bus
);
  always_comb begin
    bus = ext;
    for (int i = 0; i < NREG; i++) begin
      if (sel == SEL_W'(i + 1)) bus = regs[i];
    end
  end
endmodule

// File: rtl/dp7_alu.sv
module dp7_alu
  import dp7_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] y
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    case (op)
      OP_INC:  y = a + ONE;
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_DEC:  y = a - ONE;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      OP_SHR:  y = a >> 1;
      OP_SHL:  y = a << 1;
      default: y = a;
    endcase
  end

  // Shifts must bring in a zero at the vacated end
  always_comb begin
    if (op == OP_SHL) p_shl_fill_r8: assert (y[0] == 1'b0);
    if (op == OP_SHR) p_shr_fill_r8: assert (y[DATA_W-1] == 1'b0);
  end
endmodule

// File: rtl/dp7_datapath.sv
module dp7_datapath
  import dp7_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW_W-1:0]   ctrl_word,
  input  logic [DATA_W-1:0] ext_in,
  output logic [DATA_W-1:0] result_out
);
  ctrl_t                        cw;
  logic [NREG-1:0][DATA_W-1:0]  regs;
  logic [DATA_W-1:0]            bus_a;
  logic [DATA_W-1:0]            bus_b;
  logic [DATA_W-1:0]            alu_y;

  assign cw = ctrl_word;

  dp7_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (cw.dst),
    .wr_data (alu_y),
    .rd_all  (regs)
  );

  dp7_bus_mux #(.DATA_W(DATA_W)) u_mux_a (
    .sel  (cw.src_a),
    .ext  (ext_in),
    .regs (regs),
    .bus  (bus_a)
  );

  dp7_bus_mux #(.DATA_W(DATA_W)) u_mux_b (
    .sel  (cw.src_b),
    .ext  (ext_in),
    .regs (regs),
    .bus  (bus_b)
  );

  dp7_alu #(.DATA_W(DATA_W)) u_alu (
    .a  (bus_a),
    .b  (bus_b),
    .op (cw.op),
    .y  (alu_y)
  );

  assign result_out = alu_y;

  // Source code 0 routes the external word onto the bus
  p_ext_on_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cw.src_a == '0) |-> (bus_a == ext_in));
  p_ext_on_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cw.src_b == '0) |-> (bus_b == ext_in));

  // The chosen destination holds the previous cycle's result
  p_dest_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cw.dst != '0) |=> (regs[$past(cw.dst) - 1] == $past(alu_y)));
endmodule

// File: tb/tb_dp7_datapath.sv
module tb_dp7_datapath;
  localparam int W = 8;

  logic          clk;
  logic          rst_n;
  logic [13:0]   ctrl_word;
  logic [W-1:0]  ext_in;
  logic [W-1:0]  result_out;

  int n_checks = 0;
  int n_errors = 0;
  logic [W-1:0] model [1:7];

  dp7_datapath #(.DATA_W(W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_word  (ctrl_word),
    .ext_in     (ext_in),
    .result_out (result_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [W-1:0] exp_alu(input logic [4:0] op,
                                           input logic [W-1:0] a, b);
    case (op)
      5'b00001: return a + 8'd1;
      5'b00010: return a + b;
      5'b00101: return a - b;
      5'b00110: return a - 8'd1;
      5'b01000: return a & b;
      5'b01010: return a | b;
      5'b01100: return a ^ b;
      5'b01110: return ~a;
      5'b10000: return {1'b0, a[W-1:1]};
      5'b11000: return {a[W-2:0], 1'b0};
      default:  return a;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] got, exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // Apply one control word at the falling edge and sample the output 1 ns later
  task automatic apply(input logic [2:0] a, b, d, input logic [4:0] op,
                       input logic [W-1:0] x, output logic [W-1:0] y);
    @(negedge clk);
    ctrl_word = {a, b, d, op};
    ext_in    = x;
    #1 y = result_out;
  endtask

  task automatic read_reg(input int i, output logic [W-1:0] y);
    apply(3'(i), 3'd0, 3'd0, 5'b00000, 8'h00, y);
  endtask

  task automatic check_all_regs(input string req);
    logic [W-1:0] v;
    for (int i = 1; i <= 7; i++) begin
      read_reg(i, v);
      check(req, v, model[i]);
    end
  endtask

  task automatic t_reset;
    for (int i = 1; i <= 7; i++) model[i] = '0;
    check_all_regs("R1 reset clears registers");
  endtask

  task automatic t_load;
    logic [W-1:0] v;
    for (int i = 1; i <= 7; i++) begin
      apply(3'd0, 3'd0, 3'(i), 5'b00000, 8'(8'h13 * i + 8'h05), v);
      model[i] = 8'(8'h13 * i + 8'h05);
    end
    check_all_regs("R2 R4 load through ext on bus A");
    // Bus B selection: A=ext(0) + B=Ri gives Ri
    for (int i = 1; i <= 7; i++) begin
      apply(3'd0, 3'(i), 3'd0, 5'b00010, 8'h00, v);
      check("R2 bus B register select", v, model[i]);
    end
  endtask

  task automatic t_add_cycle;
    logic [W-1:0] v;
    logic [W-1:0] e;
    e = model[2] + model[3];
    apply(3'd2, 3'd3, 3'd1, 5'b00010, 8'h00, v);
    check("R3 R6 R1=R2+R3 result same cycle", v, e);
    model[1] = e;
    check_all_regs("R4 only R1 written");
  endtask

  task automatic t_ops;
    logic [4:0] ops [11] = '{5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110,
                             5'b01000, 5'b01010, 5'b01100, 5'b01110, 5'b10000,
                             5'b11000};
    logic [W-1:0] v;
    apply(3'd0, 3'd0, 3'd4, 5'b00000, 8'hB6, v); model[4] = 8'hB6;
    apply(3'd0, 3'd0, 3'd5, 5'b00000, 8'h5C, v); model[5] = 8'h5C;
    for (int k = 0; k < 11; k++) begin
      apply(3'd4, 3'd5, 3'd0, ops[k], 8'h00, v);
      check("R6 R7 R8 op on R4,R5", v, exp_alu(ops[k], 8'hB6, 8'h5C));
    end
    // External word on both buses
    apply(3'd0, 3'd0, 3'd0, 5'b01100, 8'hA5, v);
    check("R2 R7 ext on both buses XOR", v, 8'h00);
    apply(3'd0, 3'd0, 3'd0, 5'b00001, 8'hFF, v);
    check("R6 increment wraps", v, 8'h00);
    apply(3'd0, 3'd0, 3'd0, 5'b00110, 8'h00, v);
    check("R6 decrement wraps", v, 8'hFF);
    apply(3'd0, 3'd5, 3'd0, 5'b00101, 8'h10, v);
    check("R6 subtract borrow", v, 8'(8'h10 - 8'h5C));
    apply(3'd0, 3'd0, 3'd0, 5'b10000, 8'h81, v);
    check("R8 shift right zero fill", v, 8'h40);
    apply(3'd0, 3'd0, 3'd0, 5'b11000, 8'h81, v);
    check("R8 shift left zero fill", v, 8'h02);
  endtask

  task automatic t_unlisted;
    logic [4:0] bad [4] = '{5'b00011, 5'b00111, 5'b10101, 5'b11111};
    logic [W-1:0] v;
    for (int k = 0; k < 4; k++) begin
      apply(3'd4, 3'd5, 3'd0, bad[k], 8'h00, v);
      check("R9 unlisted op passes A", v, model[4]);
    end
  endtask

  task automatic t_discard;
    logic [W-1:0] v;
    apply(3'd1, 3'd2, 3'd0, 5'b00010, 8'h00, v);
    apply(3'd0, 3'd0, 3'd0, 5'b01110, 8'h3C, v);
    check("R5 discarded result on output", v, 8'hC3);
    check_all_regs("R5 no register written");
  endtask

  task automatic t_self;
    logic [W-1:0] v;
    logic [W-1:0] e;
    e = model[6] + model[6];
    apply(3'd6, 3'd6, 3'd6, 5'b00010, 8'h00, v);
    check("R10 self add uses old value", v, e);
    model[6] = e;
    e = model[3] - 8'd1;
    apply(3'd3, 3'd0, 3'd3, 5'b00110, 8'h00, v);
    check("R10 self decrement uses old value", v, e);
    model[3] = e;
    check_all_regs("R10 updated value visible next cycle");
  endtask

  initial begin
    rst_n     = 1'b0;
    ctrl_word = '0;
    ext_in    = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_load();
    t_add_cycle();
    t_ops();
    t_unlisted();
    t_discard();
    t_self();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    #2000000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired before the test sequence ended");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule